// File: doc/BRIEF.md
# Asynchronous DRAM Controller with Periodic Refresh

This block is a clocked sequencer between a simple host request port and an asynchronous DRAM with multiplexed row/column addressing. The host issues single-word reads and writes with a valid/ready handshake and a 20-bit word address. The controller turns each request into one strobe cycle: row address, then column address, with the row, column, write and output-enable strobes timed by programmable clock-cycle counts. Read data comes back on a one-cycle response pulse.

After reset the controller keeps every strobe inactive through a long power-up pause. It then runs a fixed number of row-strobe-only initialization cycles before it accepts any request. From then on a free-running interval timer asks for a column-before-row refresh once per row interval. A request that is already in flight finishes first; the refresh then goes ahead of any waiting host request. Every strobe phase has a minimum-length timer, so row-low time, precharge time and read access delays hold whatever the request pattern.

States: `ST_PWRUP` (pause), `ST_INIT_RAS`/`ST_INIT_PRE` (initialization pulse and its precharge), `ST_IDLE`, `ST_ROW` (row strobe active), `ST_COL` (column strobe active), `ST_REF_CAS` (column strobe leads), `ST_REF_RAS` (both strobes active), `ST_PRE` (precharge). Transitions: PWRUP→INIT_RAS when the pause ends; INIT_RAS→INIT_PRE; INIT_PRE→INIT_RAS while pulses remain, else →IDLE; IDLE→REF_CAS when a refresh is pending; IDLE→ROW on an accepted request; ROW→COL; COL→PRE; REF_CAS→REF_RAS; REF_RAS→PRE; PRE→IDLE. Every transition except those out of IDLE waits for the phase timer.

Top module: `dram_ctl`

## Requirements
- R1: After reset `dram_ras_n` and `dram_cas_n` stay high and `req_ready` stays low for at least `PWRUP_CYC` clock cycles.
- R2: Before `req_ready` first goes high, the controller issues exactly `INIT_CNT` cycles in which `dram_ras_n` falls while `dram_cas_n` is high, and no other strobe cycles.
- R3: For a host access, `dram_addr` carries `req_addr[19:10]` when `dram_ras_n` falls and `req_addr[9:0]` when `dram_cas_n` falls.
- R4: Every low period of `dram_ras_n` lasts at least `T_RAS` cycles, and every high period between two low periods lasts at least the larger of `T_RP` and `T_CP`.
- R5: For a write, `dram_we_n` is low and `dram_dq_oe` is high at least one cycle before `dram_cas_n` falls, with `dram_dq_out` equal to `req_wdata`; the word is stored at the addressed location.
- R6: For a read, `dram_oe_n` goes low with `dram_cas_n`; `dram_dq_in` is captured at a clock edge at least `T_RAC` cycles after the row strobe fell and at least `T_RCD`+max(`T_CAC`,`T_AA`,`T_OE`) cycles after it; `rsp_valid` pulses high for exactly one cycle with that word on `rsp_rdata`. With the defaults the pulse is visible in the fifth cycle after acceptance.
- R7: A refresh drives `dram_cas_n` low at least `T_CSR` cycles before `dram_ras_n` falls, with `dram_we_n` and `dram_oe_n` high and `dram_dq_oe` low.
- R8: Once initialization ends, a refresh request is raised every `REF_INT` cycles. A request raised during a host access is held and served before any waiting host request, so `req_ready` is low while it is pending. Successive refreshes are exactly `REF_INT` cycles apart when idle and within one access length of it under continuous host traffic.
- R9: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is then low until the access has finished, which with the defaults takes 7 cycles (2 row, 2 column, 3 precharge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: upper half row, lower half column |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
Writes and reads go to addresses that isolate the row and column fields: all zeros, all ones, a full column with row zero, a full row with column zero, and two alternating patterns. A swapped or shifted address half then shows up as a wrong latched row/column or a wrong read word. The memory model returns a poison word until the row, column and output-enable delays have all passed, so a read sampled too early is caught. Refresh spacing is measured once with the host idle and once under back-to-back requests: the idle run separates a correct interval from a wrong one, and the busy run separates a held, prioritised refresh from one that is lost or starved by host traffic.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_INIT_RAS,
        ST_INIT_PRE,
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_REF_CAS,
        ST_REF_RAS,
        ST_PRE
    } dram_st_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // a - b, but never below 1
    function automatic int unsigned diff_min1(int unsigned a, int unsigned b);
        return (a > b) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R4
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int unsigned INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic pend
);

    localparam int unsigned IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [IW-1:0] tick_cnt_q;
    logic          tick;
    logic          pend_q;

    assign tick = run && (tick_cnt_q == IW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
        end else if (!run || tick) begin
            tick_cnt_q <= '0;
        end else begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q && !ack) || tick;
        end
    end

    assign pend = pend_q;

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);

    // R8
    ack_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> pend);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_ctl_pkg::*;
#(
    parameter int unsigned ROW_W     = 10,
    parameter int unsigned COL_W     = 10,
    parameter int unsigned DQ_W      = 16,
    parameter int unsigned PWRUP_CYC = 10000,
    parameter int unsigned INIT_CNT  = 8,
    parameter int unsigned T_RAS     = 4,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_CP      = 1,
    parameter int unsigned T_RCD     = 2,
    parameter int unsigned T_CAS     = 1,
    parameter int unsigned T_RAC     = 4,
    parameter int unsigned T_CAC     = 1,
    parameter int unsigned T_AA      = 2,
    parameter int unsigned T_OE      = 1,
    parameter int unsigned T_CSR     = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    output logic                   rsp_valid,
    output logic [DQ_W-1:0]        rsp_rdata,
    input  logic                   ref_pend,
    output logic                   ref_ack,
    output logic                   ref_run,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [ROW_W-1:0]       dram_addr,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DQ_W-1:0]        dram_dq_in
);

    localparam int unsigned ADDR_W  = ROW_W + COL_W;
    localparam int unsigned PRE_LEN = max2(T_RP, T_CP);
    localparam int unsigned RD_LAT  = max2(T_RAC, T_RCD + max2(T_CAC, max2(T_AA, T_OE)));
    localparam int unsigned COL_LEN = max2(T_CAS, max2(diff_min1(T_RAS, T_RCD),
                                                        diff_min1(RD_LAT, T_RCD)));
    localparam int unsigned MAXLEN  = max2(PWRUP_CYC, max2(max2(T_RAS, PRE_LEN),
                                          max2(max2(T_RCD, COL_LEN), T_CSR)));
    localparam int unsigned CNT_W   = $clog2(MAXLEN + 1);
    localparam int unsigned INIT_W  = $clog2(INIT_CNT + 1);

    dram_st_e            state_q, state_d;
    logic                ph_done;
    logic                ph_load;
    logic [CNT_W-1:0]    ph_len_m1;
    logic [INIT_W-1:0]   init_cnt_q;
    logic                accept;
    logic [ADDR_W-1:0]   addr_q, addr_nxt;
    logic                we_q, we_nxt;
    logic [DQ_W-1:0]     wdata_q, wdata_nxt;
    strobe_t             strb_d, strb_q;
    logic [ROW_W-1:0]    addr_out_d;

    assign req_ready = (state_q == ST_IDLE) && !ref_pend;
    assign accept    = req_ready && req_valid;
    assign ref_ack   = (state_q == ST_IDLE) && ref_pend;
    assign ref_run   = !(state_q inside {ST_PWRUP, ST_INIT_RAS, ST_INIT_PRE});

    assign addr_nxt  = accept ? req_addr  : addr_q;
    assign we_nxt    = accept ? req_we    : we_q;
    assign wdata_nxt = accept ? req_wdata : wdata_q;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP:    if (ph_done) state_d = ST_INIT_RAS;
            ST_INIT_RAS: if (ph_done) state_d = ST_INIT_PRE;
            ST_INIT_PRE: if (ph_done) state_d = (init_cnt_q == INIT_W'(INIT_CNT - 1))
                                                ? ST_IDLE : ST_INIT_RAS;
            ST_IDLE: begin
                if (ref_pend)       state_d = ST_REF_CAS;
                else if (req_valid) state_d = ST_ROW;
            end
            ST_ROW:      if (ph_done) state_d = ST_COL;
            ST_COL:      if (ph_done) state_d = ST_PRE;
            ST_REF_CAS:  if (ph_done) state_d = ST_REF_RAS;
            ST_REF_RAS:  if (ph_done) state_d = ST_PRE;
            ST_PRE:      if (ph_done) state_d = ST_IDLE;
            default:     state_d = ST_PWRUP;
        endcase
    end

    // phase length for the state being entered
    always_comb begin
        unique case (state_d)
            ST_PWRUP:               ph_len_m1 = CNT_W'(PWRUP_CYC - 1);
            ST_INIT_RAS, ST_REF_RAS: ph_len_m1 = CNT_W'(T_RAS - 1);
            ST_INIT_PRE, ST_PRE:    ph_len_m1 = CNT_W'(PRE_LEN - 1);
            ST_ROW:                 ph_len_m1 = CNT_W'(T_RCD - 1);
            ST_COL:                 ph_len_m1 = CNT_W'(COL_LEN - 1);
            ST_REF_CAS:             ph_len_m1 = CNT_W'(T_CSR - 1);
            default:                ph_len_m1 = '0;
        endcase
    end

    assign ph_load = (state_d != state_q);

    dram_phase_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_len_m1),
        .done     (ph_done)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_PWRUP;
            init_cnt_q <= '0;
            addr_q     <= '0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT_PRE && ph_done) init_cnt_q <= init_cnt_q + 1'b1;
            addr_q  <= addr_nxt;
            we_q    <= we_nxt;
            wdata_q <= wdata_nxt;
        end
    end

    // ---------------- output decode (from next state) ----------------
    always_comb begin
        strb_d     = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        addr_out_d = '0;
        unique case (state_d)
            ST_INIT_RAS: strb_d.ras_n = 1'b0;
            ST_ROW: begin
                strb_d.ras_n = 1'b0;
                addr_out_d   = addr_nxt[ADDR_W-1:COL_W];
                if (we_nxt) begin
                    strb_d.we_n  = 1'b0;
                    strb_d.dq_oe = 1'b1;
                end
            end
            ST_COL: begin
                strb_d.ras_n = 1'b0;
                strb_d.cas_n = 1'b0;
                addr_out_d   = ROW_W'(addr_nxt[COL_W-1:0]);
                if (we_nxt) begin
                    strb_d.we_n  = 1'b0;
                    strb_d.dq_oe = 1'b1;
                end else begin
                    strb_d.oe_n  = 1'b0;
                end
            end
            ST_REF_CAS: strb_d.cas_n = 1'b0;
            ST_REF_RAS: begin
                strb_d.ras_n = 1'b0;
                strb_d.cas_n = 1'b0;
            end
            default: ;
        endcase
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q      <= '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
            dram_addr   <= '0;
            dram_dq_out <= '0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            strb_q      <= strb_d;
            dram_addr   <= addr_out_d;
            dram_dq_out <= wdata_nxt;
            rsp_valid   <= (state_q == ST_COL) && ph_done && !we_q;
            if ((state_q == ST_COL) && ph_done && !we_q) rsp_rdata <= dram_dq_in;
        end
    end

    assign dram_ras_n = strb_q.ras_n;
    assign dram_cas_n = strb_q.cas_n;
    assign dram_we_n  = strb_q.we_n;
    assign dram_oe_n  = strb_q.oe_n;
    assign dram_dq_oe = strb_q.dq_oe;

    // R1
    pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWRUP) |-> (dram_ras_n && dram_cas_n && !req_ready));

    // R9
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
    import dram_ctl_pkg::*;
#(
    parameter int unsigned ROW_W     = 10,
    parameter int unsigned COL_W     = 10,
    parameter int unsigned DQ_W      = 16,
    parameter int unsigned PWRUP_CYC = 10000,
    parameter int unsigned INIT_CNT  = 8,
    parameter int unsigned REF_INT   = 780,
    parameter int unsigned T_RAS     = 4,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_CP      = 1,
    parameter int unsigned T_RCD     = 2,
    parameter int unsigned T_CAS     = 1,
    parameter int unsigned T_RAC     = 4,
    parameter int unsigned T_CAC     = 1,
    parameter int unsigned T_AA      = 2,
    parameter int unsigned T_OE      = 1,
    parameter int unsigned T_CSR     = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    output logic                   rsp_valid,
    output logic [DQ_W-1:0]        rsp_rdata,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [ROW_W-1:0]       dram_addr,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DQ_W-1:0]        dram_dq_in
);

    localparam int unsigned PRE_LEN = max2(T_RP, T_CP);

    logic ref_pend, ref_ack, ref_run;

    dram_refresh_sched #(
        .INTERVAL (REF_INT)
    ) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ref_run),
        .ack   (ref_ack),
        .pend  (ref_pend)
    );

    dram_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
        .PWRUP_CYC(PWRUP_CYC), .INIT_CNT(INIT_CNT),
        .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_RAC(T_RAC), .T_CAC(T_CAC), .T_AA(T_AA), .T_OE(T_OE), .T_CSR(T_CSR)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_pend(ref_pend), .ref_ack(ref_ack), .ref_run(ref_run),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    // strobe-width observers for the checks below
    logic [7:0] ras_lo_cnt, ras_hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
            ras_hi_cnt <= '0;
        end else if (dram_ras_n) begin
            ras_lo_cnt <= '0;
            if (ras_hi_cnt != 8'hFF) ras_hi_cnt <= ras_hi_cnt + 1'b1;
        end else begin
            ras_hi_cnt <= '0;
            if (ras_lo_cnt != 8'hFF) ras_lo_cnt <= ras_lo_cnt + 1'b1;
        end
    end

    // R4
    ras_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (ras_lo_cnt >= 8'(T_RAS)));

    // R4
    ras_pre_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_hi_cnt >= 8'(PRE_LEN)));

    // R7
    cbr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> (dram_we_n && dram_oe_n && !dram_dq_oe));

    // R5
    write_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> (!$past(dram_we_n) && dram_dq_oe));

    // R8
    ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);

endmodule

// File: tb/dram_ctl_test.sv
module dram_ctl_test;

    localparam int PW   = 10000;
    localparam int NINI = 8;
    localparam int RI   = 780;
    localparam int TRAS = 4;
    localparam int TPRE = 3;
    localparam int TCSR = 1;
    localparam int LAT_RAS = 4;   // row-to-data delay
    localparam int LAT_CAS = 2;   // column-to-data delay
    localparam logic [15:0] POISON = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [9:0]  dram_addr;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = POISON;

    always #10 clk = ~clk;   // 50 MHz

    dram_ctl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model and strobe monitor ----------------
    logic [15:0] mem [logic [19:0]];
    int   cyc = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
    int   ras_lo = 0, ras_hi = 0, cas_lo = 0;
    logic [9:0] lat_row = '0, lat_col = '0;
    bit   ready_seen = 1'b0;
    int   init_pulses = 0;
    int   other_before_ready = 0;
    int   ref_count = 0;
    int   last_ref = 0;
    int   min_gap = 1000000, max_gap = 0;
    int   pre_viol = 0;
    int   ras_viol = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ready) ready_seen = 1'b1;
            // row strobe falls
            if (!dram_ras_n && prev_ras) begin
                if (ras_hi < TPRE) pre_viol++;
                if (!dram_cas_n) begin
                    ref_count++;
                    check(dram_we_n && dram_oe_n && !dram_dq_oe, "R7", "refresh strobes",
                          {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b110);
                    check(cas_lo >= TCSR, "R7", "cas lead before ras", cas_lo, TCSR);
                    if (last_ref != 0) begin
                        if (cyc - last_ref < min_gap) min_gap = cyc - last_ref;
                        if (cyc - last_ref > max_gap) max_gap = cyc - last_ref;
                    end
                    last_ref = cyc;
                end else begin
                    lat_row = dram_addr;
                    if (!ready_seen) init_pulses++;
                end
            end
            // row strobe rises
            if (dram_ras_n && !prev_ras) begin
                if (ras_lo < TRAS) ras_viol++;
            end
            // column strobe falls inside a row cycle
            if (!dram_cas_n && prev_cas && !dram_ras_n) begin
                lat_col = dram_addr;
                if (!ready_seen) other_before_ready++;
                if (!dram_we_n) begin
                    check(!prev_we && dram_dq_oe, "R5", "we/data setup before cas",
                          {prev_we, dram_dq_oe}, 2'b01);
                    mem[{lat_row, lat_col}] = dram_dq_out;
                end
            end
            ras_lo = dram_ras_n ? 0 : ras_lo + 1;
            ras_hi = dram_ras_n ? ras_hi + 1 : 0;
            cas_lo = dram_cas_n ? 0 : cas_lo + 1;
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_we  = dram_we_n;
            if (!dram_ras_n && !dram_cas_n && !dram_oe_n && ras_lo >= LAT_RAS && cas_lo >= LAT_CAS)
                dram_dq_in = mem.exists({lat_row, lat_col}) ? mem[{lat_row, lat_col}] : 16'h0000;
            else
                dram_dq_in = POISON;
        end
    end

    // ---------------- host request helpers ----------------
    int acc_len;    // negedges with ready low after acceptance
    int rsp_lat;    // negedges until rsp_valid seen

    task automatic issue(input bit we, input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R9", "ready drops after accept", req_ready, 1'b0);
    endtask

    task automatic do_write(input logic [19:0] a, input logic [15:0] d);
        issue(1'b1, a, d);
        while (!req_ready) @(negedge clk);
        check(lat_row == a[19:10], "R3", "row field on write", lat_row, a[19:10]);
        check(lat_col == a[9:0], "R3", "column field on write", lat_col, a[9:0]);
    endtask

    task automatic do_read(input logic [19:0] a, input logic [15:0] exp);
        logic [15:0] got;
        int pulses;
        issue(1'b0, a, 16'h0);
        got = '0;
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid) begin
                pulses++;
                got = rsp_rdata;
            end
            if (req_ready && i > 0) break;
            @(negedge clk);
        end
        check(pulses == 1, "R6", "one response pulse", pulses, 1);
        check(got == exp, "R6", "read data", got, exp);
        check(lat_row == a[19:10], "R3", "row field on read", lat_row, a[19:10]);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (4) @(negedge clk);
        check(dram_ras_n && dram_cas_n && !req_ready, "R1", "strobes in reset",
              {dram_ras_n, dram_cas_n, req_ready}, 3'b110);
        rst_n = 1'b1;
    endtask

    task automatic t_powerup();
        int n;
        bit quiet;
        n = 0;
        quiet = 1'b1;
        @(negedge clk);
        while (dram_ras_n && n < PW + 50) begin
            if (!dram_cas_n || req_ready) quiet = 1'b0;
            n++;
            @(negedge clk);
        end
        check(quiet, "R1", "strobes idle during pause", quiet, 1'b1);
        check(n >= PW - 1, "R1", "pause length", n, PW);
        while (!req_ready) @(negedge clk);
        check(init_pulses == NINI, "R2", "init pulse count", init_pulses, NINI);
        check(other_before_ready == 0, "R2", "no column cycle during init",
              other_before_ready, 0);
    endtask

    localparam int NPAT = 6;
    logic [19:0] pat_a [NPAT] = '{20'h00000, 20'hFFFFF, 20'h003FF, 20'hFFC00, 20'h5A5A5, 20'hA5A5A};
    logic [15:0] pat_d [NPAT] = '{16'h1111, 16'hFFFF, 16'h03FF, 16'hC000, 16'h5AA5, 16'hA55A};

    task automatic t_write_read();
        for (int i = 0; i < NPAT; i++) do_write(pat_a[i], pat_d[i]);
        for (int i = NPAT - 1; i >= 0; i--) do_read(pat_a[i], pat_d[i]);
        // overwrite and read back
        do_write(20'h5A5A5, 16'h0F0F);
        do_read(20'h5A5A5, 16'h0F0F);
        do_read(20'hA5A5A, 16'hA55A);
    endtask

    task automatic t_handshake();
        int rc;
        rc = ref_count;
        while (ref_count == rc) @(negedge clk);
        repeat (10) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = 1'b0;
        req_addr  = 20'hFFFFF;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        acc_len = 0;
        rsp_lat = 0;
        for (int i = 1; i < 30; i++) begin
            if (rsp_valid && rsp_lat == 0) rsp_lat = i;
            if (req_ready) break;
            acc_len++;
            @(negedge clk);
        end
        check(acc_len == 7, "R9", "access busy length", acc_len, 7);
        check(rsp_lat == 5, "R6", "read response latency", rsp_lat, 5);
        check(rsp_rdata == 16'hFFFF, "R6", "handshake read data", rsp_rdata, 16'hFFFF);
    endtask

    task automatic t_refresh_idle();
        int rc;
        rc = ref_count;
        min_gap = 1000000;
        max_gap = 0;
        repeat (4 * RI + 5) @(negedge clk);
        check(ref_count - rc >= 4 && ref_count - rc <= 5, "R8", "idle refresh count",
              ref_count - rc, 4);
        check(min_gap == RI && max_gap == RI, "R8", "idle refresh spacing",
              {min_gap[15:0], max_gap[15:0]}, {RI[15:0], RI[15:0]});
    endtask

    task automatic t_refresh_busy();
        int rc, t0, k;
        rc = ref_count;
        t0 = cyc;
        k = 0;
        min_gap = 1000000;
        max_gap = 0;
        while (cyc - t0 < 4 * RI) begin
            do_read(pat_a[k % NPAT], (k % NPAT == 4) ? 16'h0F0F : pat_d[k % NPAT]);
            k++;
        end
        check(ref_count - rc >= 3 && ref_count - rc <= 5, "R8", "busy refresh count",
              ref_count - rc, 4);
        check(max_gap <= RI + 10 && min_gap >= RI - 10, "R8", "busy refresh spacing",
              {min_gap[15:0], max_gap[15:0]}, {RI[15:0], RI[15:0]});
    endtask

    task automatic t_widths();
        check(ras_viol == 0, "R4", "row strobe low width", ras_viol, 0);
        check(pre_viol == 0, "R4", "precharge width", pre_viol, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_write_read();
        t_handshake();
        t_refresh_idle();
        t_refresh_busy();
        t_widths();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule